// File: doc/BRIEF.md
# Vectored 64-Source Interrupt Controller

This block gathers up to 63 active-low interrupt request lines into a single interrupt output for a processor. Vector 0 is reserved to mean "nothing active", so it has no request line. Software reaches the block over a plain register bus with an address, a write strobe, 32-bit write data and combinational 32-bit read data. There are two enable words, two pending words, one sense-control word and one read-only vector word.

A source's enable and pending bits are not placed at the bit that matches its number. A fixed scramble spreads the vectors across a high word and a low word, so software has to know the placement to reach a given source. Each request line passes through a synchroniser before anything else sees it. Most sources are level sensed and active low. Seven external lines can instead be set to latch on a falling edge. Sixteen port lines latch on both edges, or on the falling edge only.

The vector word reports the lowest-numbered source that is both pending and enabled. The interrupt output stays high while any such source exists. The bus is a control path with no back-pressure: every write takes effect on the clock edge at which `bus_we` is sampled high.

Top module: `vec_irq_ctrl`

## Requirements
- R1: After reset, every enable, pending and sense-control bit is 0, all six registers read 0, and `irq` is low.
- R2: A 1 in an enable bit lets its source reach the vector word and `irq`, and a 0 blocks it. A blocked source still shows in the pending words. Enable bit 0 of the low word belongs to vector 0, has no storage and always reads 0.
- R3: Placement of vector v, where "high" is the high word. v=1..15 goes to low bit 16−v. v=16..18 goes to high bit 18−v. v=19..30 goes to high bit 33−v. v=31 goes to high bit 15. v=32..47 goes to low bit 63−v. v=48..63 goes to high bit v−32. The same placement applies to both enable words and both pending words.
- R4: Writing 1 to a pending bit clears a latched edge event, and writing 0 leaves the bit unchanged. The pending bit of a level-sensed source follows its line (1 while the line is low), and pending writes do not affect it.
- R5: Every source outside 19..25 and 48..63 is sensed active-low level, whatever the sense-control word holds.
- R6: External sources 19..25 use sense-control bit 33−v. When that bit is 1, the source latches pending on a falling edge. When it is 0, the source is level low.
- R7: Port sources 48..63 use sense-control bit v−32 and are always edge latched. When that bit is 1, only falling edges set pending. When it is 0, both falling and rising edges set pending.
- R8: Only sense-control bits 8..14 and 16..31 are stored. All other bits read 0.
- R9: The vector word holds, in bits [31:26], the lowest nonzero vector that is both pending and enabled, or 0 if there is none. Bits [25:0] read 0.
- R10: `irq` is high exactly when some source is both pending and enabled.
- R11: The register addresses are: 0 enable-high, 1 enable-low, 2 pending-high, 3 pending-low, 4 sense-control, 5 vector. Writes to 5, 6 and 7 change nothing, and reads of 6 and 7 return 0.
- R12: A change on a request line reaches pending after the synchroniser, two clock edges by default.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_n | input | 64 | Active-low request lines indexed by vector; bit 0 unused |
| bus_addr | input | 3 | Register select |
| bus_we | input | 1 | Write strobe, sampled at the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| irq | output | 1 | Interrupt request to the processor |

## Verification
The bench sweeps every one of the 63 vectors alone. For each one it checks the exact pending bit against the placement arithmetic, so a design with one swapped entry in the scramble, or a collision in the high word, lights the wrong bit. Level sources are checked to ignore a write-1 clear and to drop when the line is released; a design that latched them would keep `irq` high. With all sense bits set, the bench checks that external and port sources stay cleared across the rising edge, and that port sources set pending again on a rising edge when their sense bit is clear; a design with the edge polarity or the both-edges mode wrong misses one of these. A three-source priority run, with the sources released one by one and then masked, catches a design that picks the highest vector or that lets masked sources raise `irq`.

// File: rtl/vic_pkg.sv
package vic_pkg;

  localparam int NUM_VEC  = 64;
  localparam int WORD_W   = 32;
  localparam int VID_W    = $clog2(NUM_VEC);
  localparam int ADDR_W   = 3;

  localparam logic [ADDR_W-1:0] ADR_EN_HI   = 3'd0;
  localparam logic [ADDR_W-1:0] ADR_EN_LO   = 3'd1;
  localparam logic [ADDR_W-1:0] ADR_PEND_HI = 3'd2;
  localparam logic [ADDR_W-1:0] ADR_PEND_LO = 3'd3;
  localparam logic [ADDR_W-1:0] ADR_SENSE   = 3'd4;
  localparam logic [ADDR_W-1:0] ADR_VECTOR  = 3'd5;

  // Stored sense-control bits: external group 8..14, port group 16..31
  localparam logic [WORD_W-1:0] SENSE_KEEP = 32'hFFFF_7F00;

  typedef enum logic [1:0] {
    KIND_NONE,
    KIND_LEVEL,
    KIND_EXT,
    KIND_PORT
  } src_kind_e;

  function automatic src_kind_e kind_of(int v);
    if (v == 0)              return KIND_NONE;
    if (v >= 19 && v <= 25)  return KIND_EXT;
    if (v >= 48)             return KIND_PORT;
    return KIND_LEVEL;
  endfunction

  // 1 selects the high word
  function automatic bit in_high(int v);
    return (v >= 16 && v <= 31) || (v >= 48);
  endfunction

  function automatic int bit_of(int v);
    if (v == 0)  return 0;
    if (v <= 15) return 16 - v;
    if (v <= 18) return 18 - v;
    if (v <= 30) return 33 - v;
    if (v == 31) return 15;
    if (v <= 47) return 63 - v;
    return v - 32;
  endfunction

  function automatic int sense_pos(int v);
    if (v >= 19 && v <= 25) return 33 - v;
    if (v >= 48)            return v - 32;
    return 0;
  endfunction

endpackage

// File: rtl/vic_sync.sv
module vic_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_in,
  output logic d_out
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '1;
    else        chain_q <= {chain_q[STAGES-2:0], d_in};
  end

  assign d_out = chain_q[STAGES-1];

endmodule

// File: rtl/vic_src_cell.sv
module vic_src_cell
  import vic_pkg::*;
#(
  parameter int        STAGES = 2,
  parameter src_kind_e KIND   = KIND_LEVEL
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_n,
  input  logic sense_sel,
  input  logic clr,
  output logic pend
);

  logic line_s;
  logic prev_q;
  logic latch_q;
  logic fall_evt;
  logic rise_evt;
  logic edge_mode;
  logic set_evt;

  vic_sync #(.STAGES(STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d_in (line_n),
    .d_out(line_s)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= line_s;
  end

  assign fall_evt = prev_q & ~line_s;
  assign rise_evt = ~prev_q & line_s;

  generate
    if (KIND == KIND_EXT) begin : g_ext
      assign edge_mode = sense_sel;
      assign set_evt   = fall_evt;
    end else if (KIND == KIND_PORT) begin : g_port
      assign edge_mode = 1'b1;
      assign set_evt   = sense_sel ? fall_evt : (fall_evt | rise_evt);
    end else begin : g_lvl
      assign edge_mode = 1'b0;
      assign set_evt   = 1'b0;
    end
  endgenerate

  // An edge arriving with a clear in the same cycle wins
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         latch_q <= 1'b0;
    else if (!edge_mode) latch_q <= 1'b0;
    else                latch_q <= (latch_q & ~clr) | set_evt;
  end

  assign pend = edge_mode ? latch_q : ~line_s;

endmodule

// File: rtl/vic_wordmap.sv
module vic_wordmap
  import vic_pkg::*;
(
  input  logic [NUM_VEC-1:0] vec_bits,
  output logic [WORD_W-1:0]  hi_w,
  output logic [WORD_W-1:0]  lo_w
);

  generate
    for (genvar v = 0; v < NUM_VEC; v++) begin : g_map
      localparam int BP = bit_of(v);
      if (in_high(v)) begin : g_hi
        assign hi_w[BP] = vec_bits[v];
      end else begin : g_lo
        assign lo_w[BP] = vec_bits[v];
      end
    end
  endgenerate

endmodule

// File: rtl/vic_prio_enc.sv
module vic_prio_enc #(
  parameter int N    = 64,
  localparam int ID_W = $clog2(N)
) (
  input  logic [N-1:0]    req,
  output logic [ID_W-1:0] win,
  output logic            any
);

  always_comb begin
    win = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) win = ID_W'(i);
    end
    any = |req;
  end

endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl
  import vic_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [63:0]       src_n,
  input  logic [2:0]        bus_addr,
  input  logic              bus_we,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq
);

  logic [NUM_VEC-1:0] mask_v;
  logic [NUM_VEC-1:0] pend_v;
  logic [NUM_VEC-1:0] clr_v;
  logic [WORD_W-1:0]  sense_q;
  logic [WORD_W-1:0]  mask_hi_w, mask_lo_w;
  logic [WORD_W-1:0]  pend_hi_w, pend_lo_w;
  logic [VID_W-1:0]   win_id;
  logic               any_act;

  // Sense-control word
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sense_q <= '0;
    else if (bus_we && bus_addr == ADR_SENSE) sense_q <= bus_wdata & SENSE_KEEP;
  end

  assign mask_v[0] = 1'b0;
  assign pend_v[0] = 1'b0;
  assign clr_v[0]  = 1'b0;

  generate
    for (genvar v = 1; v < NUM_VEC; v++) begin : g_vec
      localparam int              BP   = bit_of(v);
      localparam logic [ADDR_W-1:0] EN_A = in_high(v) ? ADR_EN_HI : ADR_EN_LO;
      localparam logic [ADDR_W-1:0] PD_A = in_high(v) ? ADR_PEND_HI : ADR_PEND_LO;
      localparam src_kind_e       KND  = kind_of(v);

      logic sel;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mask_v[v] <= 1'b0;
        else if (bus_we && bus_addr == EN_A) mask_v[v] <= bus_wdata[BP];
      end

      assign clr_v[v] = bus_we && (bus_addr == PD_A) && bus_wdata[BP];

      if (KND == KIND_EXT || KND == KIND_PORT) begin : g_sel
        assign sel = sense_q[sense_pos(v)];
      end else begin : g_nosel
        assign sel = 1'b0;
      end

      vic_src_cell #(.STAGES(SYNC_STAGES), .KIND(KND)) u_cell (
        .clk      (clk),
        .rst_n    (rst_n),
        .line_n   (src_n[v]),
        .sense_sel(sel),
        .clr      (clr_v[v]),
        .pend     (pend_v[v])
      );
    end
  endgenerate

  vic_wordmap u_mask_map (
    .vec_bits(mask_v),
    .hi_w    (mask_hi_w),
    .lo_w    (mask_lo_w)
  );

  vic_wordmap u_pend_map (
    .vec_bits(pend_v),
    .hi_w    (pend_hi_w),
    .lo_w    (pend_lo_w)
  );

  vic_prio_enc #(.N(NUM_VEC)) u_prio (
    .req(pend_v & mask_v),
    .win(win_id),
    .any(any_act)
  );

  assign irq = any_act;

  always_comb begin
    case (bus_addr)
      ADR_EN_HI:   bus_rdata = mask_hi_w;
      ADR_EN_LO:   bus_rdata = mask_lo_w;
      ADR_PEND_HI: bus_rdata = pend_hi_w;
      ADR_PEND_LO: bus_rdata = pend_lo_w;
      ADR_SENSE:   bus_rdata = sense_q;
      ADR_VECTOR:  bus_rdata = {win_id, {(WORD_W-VID_W){1'b0}}};
      default:     bus_rdata = '0;
    endcase
  end

  wire unused_src0 = src_n[0];

endmodule

// File: rtl/vic_checker.sv
module vic_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        irq,
  input logic [5:0]  win_id,
  input logic [63:0] pend_v,
  input logic [63:0] mask_v,
  input logic        bus_we,
  input logic [2:0]  bus_addr,
  input logic [31:0] bus_wdata,
  input logic [31:0] mask_lo_w
);

  logic [63:0] below_win;
  assign below_win = (64'd1 << win_id) - 64'd1;

  AST_IRQ_HAS_WINNER: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (win_id != 6'd0)) else $error("irq without winner"); // R10

  AST_WINNER_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    (win_id != 6'd0) |-> pend_v[win_id]) else $error("winner not pending"); // R9

  AST_WINNER_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    (win_id != 6'd0) |-> mask_v[win_id]) else $error("winner masked"); // R2

  AST_WINNER_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
    (win_id != 6'd0) |-> ((pend_v & mask_v & below_win) == 64'd0)) else $error("lower source skipped"); // R9

  AST_ENLO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == 3'd1) |=> (mask_lo_w == ($past(bus_wdata) & 32'hFFFF_FFFE))) else $error("enable-low write"); // R3

endmodule

bind vec_irq_ctrl vic_checker u_vic_checker (
  .clk      (clk),
  .rst_n    (rst_n),
  .irq      (irq),
  .win_id   (win_id),
  .pend_v   (pend_v),
  .mask_v   (mask_v),
  .bus_we   (bus_we),
  .bus_addr (bus_addr),
  .bus_wdata(bus_wdata),
  .mask_lo_w(mask_lo_w)
);

// File: tb/test_vec_irq_ctrl.sv
`timescale 1ns/1ps
module test_vec_irq_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] src_n = '1;
  logic [2:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  vec_irq_ctrl i_vec_irq_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .src_n    (src_n),
    .bus_addr (bus_addr),
    .bus_we   (bus_we),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .irq      (irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Placement from R3
  function automatic void place(input int v, output bit hi, output int b);
    if (v >= 48)      begin hi = 1; b = 16 + (v - 48); end
    else if (v >= 32) begin hi = 0; b = 31 - (v - 32); end
    else if (v == 31) begin hi = 1; b = 15; end
    else if (v >= 19) begin hi = 1; b = 14 - (v - 19); end
    else if (v >= 16) begin hi = 1; b = 2 - (v - 16); end
    else              begin hi = 0; b = 16 - v; end
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    bit hi; int b;
    logic [2:0] ea, pa, oa;

    idle(3);
    rst_n = 1'b1;
    idle(2);

    // R1 reset state
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), r);
      chk("R1 reset reg", r, 32'h0);
    end
    chk("R1 irq after reset", {31'b0, irq}, 32'h0);

    // Sweep every vector with default sense
    for (int v = 1; v < 64; v++) begin
      place(v, hi, b);
      ea = hi ? 3'd0 : 3'd1;
      pa = hi ? 3'd2 : 3'd3;
      oa = hi ? 3'd3 : 3'd2;
      wr(3'd0, 32'h0); wr(3'd1, 32'h0);
      wr(ea, 32'h1 << b);
      src_n[v] = 1'b0;
      idle(5);
      rd(pa, r); chk($sformatf("R3 pend v%0d", v), r, 32'h1 << b);
      rd(oa, r); chk($sformatf("R3 other word v%0d", v), r, 32'h0);
      rd(3'd5, r); chk($sformatf("R9 vector v%0d", v), r, 32'(v) << 26);
      chk($sformatf("R10 irq v%0d", v), {31'b0, irq}, 32'h1);
      if (v >= 48) begin
        wr(pa, 32'h1 << b);
        rd(pa, r); chk($sformatf("R4 clear port v%0d", v), r, 32'h0);
        src_n[v] = 1'b1;
        idle(5);
        rd(pa, r); chk($sformatf("R7 rise sets v%0d", v), r, 32'h1 << b);
        wr(pa, 32'hFFFF_FFFF);
        rd(pa, r); chk($sformatf("R4 clear again v%0d", v), r, 32'h0);
      end else begin
        wr(pa, 32'hFFFF_FFFF);
        rd(pa, r); chk($sformatf("R4 level ignores clear v%0d", v), r, 32'h1 << b);
        src_n[v] = 1'b1;
        idle(5);
        rd(pa, r); chk($sformatf("R5 R6 level drops v%0d", v), r, 32'h0);
        chk($sformatf("R10 irq low v%0d", v), {31'b0, irq}, 32'h0);
      end
    end

    // R8 sense storage
    wr(3'd4, 32'hFFFF_FFFF);
    rd(3'd4, r); chk("R8 sense readback", r, 32'hFFFF_7F00);
    // R2 enable bit of vector 0
    wr(3'd0, 32'hFFFF_FFFF); wr(3'd1, 32'hFFFF_FFFF);
    rd(3'd1, r); chk("R2 enable low readback", r, 32'hFFFF_FFFE);
    rd(3'd0, r); chk("R2 enable high readback", r, 32'hFFFF_FFFF);

    // Falling-edge-only sweep for external and port groups
    for (int v = 19; v < 64; v++) begin
      if (v > 25 && v < 48) continue;
      place(v, hi, b);
      pa = hi ? 3'd2 : 3'd3;
      src_n[v] = 1'b0;
      idle(5);
      rd(pa, r); chk($sformatf("R6 R7 fall latches v%0d", v), r, 32'h1 << b);
      wr(pa, 32'h1 << b);
      rd(pa, r); chk($sformatf("R4 edge clear while low v%0d", v), r, 32'h0);
      src_n[v] = 1'b1;
      idle(5);
      rd(pa, r); chk($sformatf("R6 R7 rise ignored v%0d", v), r, 32'h0);
    end

    // R5 internal source unaffected by sense word
    src_n[5] = 1'b0;
    idle(5);
    wr(3'd3, 32'hFFFF_FFFF);
    rd(3'd3, r); chk("R5 internal stays level", r, 32'h1 << 11);
    src_n[5] = 1'b1;
    idle(5);
    rd(3'd3, r); chk("R5 internal released", r, 32'h0);
    wr(3'd4, 32'h0);

    // R12 synchroniser latency on a level source (vector 7, low bit 9)
    @(negedge clk);
    src_n[7] = 1'b0;
    @(negedge clk); #1;
    chk("R12 not yet after one edge", {31'b0, irq}, 32'h0);
    @(negedge clk); #1;
    chk("R12 seen after two edges", {31'b0, irq}, 32'h1);
    src_n[7] = 1'b1;
    idle(5);

    // R9 priority among three level sources
    src_n[40] = 1'b0; src_n[7] = 1'b0; src_n[20] = 1'b0;
    idle(5);
    rd(3'd5, r); chk("R9 lowest wins 7", r, 32'd7 << 26);
    src_n[7] = 1'b1; idle(5);
    rd(3'd5, r); chk("R9 next 20", r, 32'd20 << 26);
    src_n[20] = 1'b1; idle(5);
    rd(3'd5, r); chk("R9 next 40", r, 32'd40 << 26);
    // R2 masked source stays pending but silent
    wr(3'd1, 32'h0);
    rd(3'd5, r); chk("R2 masked vector", r, 32'h0);
    chk("R2 masked irq", {31'b0, irq}, 32'h0);
    rd(3'd3, r); chk("R2 still pending", r, 32'h1 << 23);
    // R11 writes with no effect
    wr(3'd5, 32'hFFFF_FFFF);
    wr(3'd6, 32'hFFFF_FFFF);
    wr(3'd7, 32'hFFFF_FFFF);
    rd(3'd1, r); chk("R11 enable untouched", r, 32'h0);
    rd(3'd4, r); chk("R11 sense untouched", r, 32'h0);
    rd(3'd6, r); chk("R11 unused reads 0", r, 32'h0);
    rd(3'd7, r); chk("R11 unused 7 reads 0", r, 32'h0);
    wr(3'd3, 32'h0);
    rd(3'd3, r); chk("R4 zero write no change", r, 32'h1 << 23);
    src_n[40] = 1'b1;
    idle(5);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule